// File: doc/BRIEF.md
# Banked Edge-Interrupt GPIO Controller

This block is a byte-wide register file for 48 general-purpose lines, arranged as six 8-bit ports. A host reaches it through a simple synchronous bus with a 4-bit address, an 8-bit write path, a single write strobe and a combinational read path. Writing a port offset loads that port's output latch. Reading a port offset returns the port's pin levels after a two-flop synchroniser.

The three lowest ports can raise interrupts on edges, one bit at a time. Each of these ports has three registers: an enable register, an edge-polarity register and a sticky event register. All three share one window of three addresses. A page code held at offset 7 chooses which of them the window shows.

Offset 6 gives a per-port pending summary. The single active-high interrupt output stays asserted while any event bit is set. The host acknowledges an event by writing its enable bit to 0 and then back to 1.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: A write to offset p (0..5) loads data into output latch p. `pin_out[8p+7:8p]` shows it from the next clock. All latches reset to 0x00, and a write to one port leaves the other ports unchanged.
- R2: A read of offset p (0..5) returns `pin_in[8p+7:8p]` after two register stages. A pin change driven between two rising edges is visible after the second of the following two edges, and not after the first.
- R3: Offset 7 holds the page code. It resets to 0xC0 and reads back the last value written. In the window at offsets 8..10, code 0x80 selects the enable registers, 0x40 the polarity registers and 0xC0 the event registers of ports 0..2. Any other code reads 0x00 and ignores writes.
- R4: Under pages 0x80 and 0x40, a read of offset 8+n returns the value last written there for port n.
- R5: Polarity bit 1 means rising edge and 0 means falling edge. An enabled bit records its selected edge in its event bit within three clock edges of the pin change, and the event bit stays set after the pin returns. A bit whose enable is 0 never records an event.
- R6: Writing 0 to an enable bit clears that event bit on the same clock edge that stores the write. Setting the enable bit to 1 again leaves the event bit clear until a new edge arrives, so the pair of writes acknowledges the event.
- R7: A read of offset 6 returns in bit n (n = 0..2) the OR of port n's event bits. Bits 7:3 read 0.
- R8: `irq` is high when any event bit is set. It stays high until the last event bit is cleared and falls on the clock edge that clears it.
- R9: Writes to offsets 8..10 while page 0xC0 is selected change no enable, polarity or event bit.
- R10: Ports 3..5 never cause events, summary bits or `irq`. Offsets 11..15 read 0x00. After reset all enable and event bits are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 48 | Line levels from the pads |
| pin_out | output | 48 | Output latch contents |
| irq | output | 1 | Interrupt, high while any event is latched |

## Verification
The bench drives rising and falling edges at the same time on one port whose polarity register is mixed. It then checks that each bit records only its own edge direction. A design with the polarity sense inverted, or one that detects both edges, would show the wrong event byte. The acknowledge path is checked one bit at a time and then for all bits, with `irq` sampled on the exact edge that clears the last enable. A design that cleared events one cycle late, or left the event set after re-enabling, would keep `irq` high. Further checks confirm that writes under the event page and under an undefined page code change nothing, that edges on disabled bits and on ports 3..5 stay silent, and that the synchroniser latency is exactly two edges.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int NPORT = 6,
  parameter int NIRQ = 3,
  parameter int W = 8,
  parameter int AW = 4,
  parameter logic [7:0] PG_EN = 8'h80,
  parameter logic [7:0] PG_POL = 8'h40,
  parameter logic [7:0] PG_EV = 8'hC0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [W-1:0]         bus_wdata,
  output logic [W-1:0]         bus_rdata,
  input  logic [NPORT*W-1:0]   pin_in,
  output logic [NPORT*W-1:0]   pin_out,
  output logic                 irq
);
  localparam int NL = NPORT * W;
  localparam int NI = NIRQ * W;
  localparam logic [AW-1:0] A_SUM = AW'(NPORT);
  localparam logic [AW-1:0] A_PAGE = AW'(NPORT + 1);
  localparam logic [AW-1:0] A_WIN = AW'(NPORT + 2);

  logic [NL-1:0] s1, s2, out_q;
  logic [NI-1:0] prv, en, pol, ev;
  logic [W-1:0] page;
  logic [NIRQ-1:0] pend;
  logic win_wr;

  assign pin_out = out_q;
  assign irq = |pend;
  assign win_wr = bus_wr && (bus_addr >= A_WIN) && (bus_addr < A_WIN + AW'(NIRQ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      prv <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      prv <= s2[NI-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page <= PG_EV;
    else if (bus_wr && bus_addr == A_PAGE) page <= bus_wdata;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[p*W +: W] <= '0;
      else if (bus_wr && bus_addr == AW'(p)) out_q[p*W +: W] <= bus_wdata;
    end

    p_out_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(p)) |=> (pin_out[p*W +: W] == $past(bus_wdata)));
  end

  for (genvar p = 0; p < NIRQ; p++) begin : g_irq
    logic sel;
    logic [W-1:0] en_nx, hit, cur, old;
    assign sel = bus_wr && bus_addr == AW'(NPORT + 2 + p);
    assign en_nx = (sel && page == PG_EN) ? bus_wdata : en[p*W +: W];
    assign cur = s2[p*W +: W];
    assign old = prv[p*W +: W];
    assign hit = en[p*W +: W] & ((pol[p*W +: W] & cur & ~old) | (~pol[p*W +: W] & ~cur & old));
    assign pend[p] = |ev[p*W +: W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en[p*W +: W] <= '0;
        pol[p*W +: W] <= '0;
        ev[p*W +: W] <= '0;
      end else begin
        en[p*W +: W] <= en_nx;
        if (sel && page == PG_POL) pol[p*W +: W] <= bus_wdata;
        ev[p*W +: W] <= en_nx & (ev[p*W +: W] | hit);
      end
    end

    p_ev_page_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && page == PG_EV) |=> ($stable(en[p*W +: W]) && $stable(pol[p*W +: W])));
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORT; p++)
      if (bus_addr == AW'(p)) bus_rdata = s2[p*W +: W];
    if (bus_addr == A_SUM) bus_rdata[NIRQ-1:0] = pend;
    if (bus_addr == A_PAGE) bus_rdata = page;
    for (int p = 0; p < NIRQ; p++)
      if (bus_addr == AW'(NPORT + 2 + p)) begin
        if (page == PG_EN) bus_rdata = en[p*W +: W];
        else if (page == PG_POL) bus_rdata = pol[p*W +: W];
        else if (page == PG_EV) bus_rdata = ev[p*W +: W];
      end
  end

  p_ev_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev & ~en) == '0);

  p_ev_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev & ~$past(ev) & ~$past(en)) == '0));

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(win_wr && page == PG_EN)) |=> irq);

  p_sum_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SUM) |-> (bus_rdata[W-1:NIRQ] == '0));
endmodule

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
  logic clk = 0;
  logic rst_n = 0;
  logic bus_wr = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out;
  logic irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_edge_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq(irq)
  );

  // {kind, addr, data}: kind 0 write, 1 read compare, 2 output latch compare
  localparam logic [15:0] VEC [14] = '{
    16'h00A5, 16'h20A5, 16'h053C, 16'h253C, 16'h03FF, 16'h23FF, 16'h20A5,
    16'h0780, 16'h1780, 16'h07C0, 16'h17C0, 16'h1600, 16'h1C00, 16'h1F00
  };

  task automatic chk(string tag, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string vtag(logic [3:0] k, logic [3:0] a);
    if (k == 2) return "R1";
    if (a == 7) return "R3";
    if (a == 6) return "R7";
    return "R10";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk("R1 reset latches", pin_out, 48'h0);
    chk("R10 reset irq", {47'h0, irq}, 48'h0);
    rd(4'd7, r); chk("R3 reset page", {40'h0, r}, 48'hC0);
    wr(4'd7, 8'h80);
    rd(4'd8, r); chk("R10 reset enable", {40'h0, r}, 48'h0);
    wr(4'd7, 8'hC0);

    // vector table
    foreach (VEC[i]) begin
      logic [3:0] k = VEC[i][15:12];
      logic [3:0] a = VEC[i][11:8];
      logic [7:0] d = VEC[i][7:0];
      if (k == 0) wr(a, d);
      else if (k == 1) begin rd(a, r); chk(vtag(k, a), {40'h0, r}, {40'h0, d}); end
      else begin @(negedge clk); chk(vtag(k, a), {40'h0, pin_out[a*8 +: 8]}, {40'h0, d}); end
    end

    // R2 synchroniser latency and pin read mapping
    @(negedge clk);
    bus_addr = 4'd0;
    pin_in = 48'h123456789ABC;
    @(negedge clk); #1 chk("R2 one edge old", {40'h0, bus_rdata}, 48'h0);
    @(negedge clk); #1 chk("R2 two edges new", {40'h0, bus_rdata}, 48'hBC);
    for (int p = 1; p < 6; p++) begin
      rd(4'(p), r); chk("R2 port read", {40'h0, r}, {40'h0, pin_in[p*8 +: 8]});
    end
    pin_in = '0;
    settle(4);

    // R4 enable and polarity readback; R5 mixed polarity on port 0
    wr(4'd7, 8'h40); wr(4'd8, 8'h0F);
    rd(4'd8, r); chk("R4 polarity readback", {40'h0, r}, 48'h0F);
    wr(4'd7, 8'h80); wr(4'd8, 8'hFF);
    rd(4'd8, r); chk("R4 enable readback", {40'h0, r}, 48'hFF);
    wr(4'd7, 8'hC0);
    rd(4'd8, r); chk("R5 no edge no event", {40'h0, r}, 48'h0);
    pin_in[7:0] = 8'hFF; settle(4);
    rd(4'd8, r); chk("R5 rising bits only", {40'h0, r}, 48'h0F);
    rd(4'd6, r); chk("R7 summary port0", {40'h0, r}, 48'h01);
    chk("R8 irq raised", {47'h0, irq}, 48'h1);
    pin_in[7:0] = 8'h00; settle(4);
    rd(4'd8, r); chk("R5 falling added, sticky", {40'h0, r}, 48'hFF);

    // R9 writes under event page ignored
    wr(4'd8, 8'h00);
    rd(4'd8, r); chk("R9 event unchanged", {40'h0, r}, 48'hFF);
    wr(4'd7, 8'h80);
    rd(4'd8, r); chk("R9 enable unchanged", {40'h0, r}, 48'hFF);
    wr(4'd7, 8'h40);
    rd(4'd8, r); chk("R9 polarity unchanged", {40'h0, r}, 48'h0F);

    // R6 acknowledge one bit, then all
    wr(4'd7, 8'h80); wr(4'd8, 8'hFE); wr(4'd8, 8'hFF);
    wr(4'd7, 8'hC0);
    rd(4'd8, r); chk("R6 single ack", {40'h0, r}, 48'hFE);
    chk("R8 irq held", {47'h0, irq}, 48'h1);
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h00);
    chk("R8 irq falls on clear edge", {47'h0, irq}, 48'h0);
    wr(4'd8, 8'hFF);
    wr(4'd7, 8'hC0);
    rd(4'd8, r); chk("R6 re-enable stays clear", {40'h0, r}, 48'h0);
    rd(4'd6, r); chk("R7 summary clear", {40'h0, r}, 48'h0);

    // R5 port 2 rising, port 1 disabled
    wr(4'd7, 8'h40); wr(4'd10, 8'h20);
    wr(4'd7, 8'h80); wr(4'd10, 8'h20);
    wr(4'd7, 8'hC0);
    pin_in[23:8] = 16'hFFFF; settle(4);
    rd(4'd10, r); chk("R5 port2 rising", {40'h0, r}, 48'h20);
    rd(4'd9, r); chk("R5 disabled port1 silent", {40'h0, r}, 48'h0);
    rd(4'd6, r); chk("R7 summary port2", {40'h0, r}, 48'h04);
    wr(4'd7, 8'h80); wr(4'd10, 8'h00);
    chk("R8 irq cleared", {47'h0, irq}, 48'h0);

    // R10 upper ports never interrupt
    pin_in[47:24] = 24'hFFFFFF; settle(4);
    pin_in[47:24] = 24'h000000; settle(4);
    rd(4'd6, r); chk("R10 upper ports no summary", {40'h0, r}, 48'h0);
    chk("R10 upper ports no irq", {47'h0, irq}, 48'h0);
    rd(4'd11, r); chk("R10 offset 11 zero", {40'h0, r}, 48'h0);

    // R3 undefined page code
    wr(4'd7, 8'h00);
    rd(4'd8, r); chk("R3 undefined page reads zero", {40'h0, r}, 48'h0);
    wr(4'd8, 8'h00);
    wr(4'd7, 8'h80);
    rd(4'd8, r); chk("R3 undefined page write ignored", {40'h0, r}, 48'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule